// File: doc/BRIEF.md
# Page-Latched Byte Store with Timed Commit

This block sits behind a two-wire bus slave and turns the data phase of a write transaction into one array update. The bus side first presents the 10-bit word address, then streams bytes in with a load strobe. Each byte lands in a 16-slot page latch at the slot chosen by the low four address bits. The slot pointer then steps and wraps inside the page, so the upper six bits never change. A per-slot valid mask records which slots were filled.

A commit pulse at STOP starts a self-timed write cycle. The cycle lasts a programmable number of clocks and models erase-then-program. When it ends, the filled slots replace their bytes in a 1024-byte register-file array. The other bytes of the page stay as they were. A pending commit is dropped when write protect is high or nothing was loaded. An abort, meaning a repeated START before STOP, discards the latch contents. While the cycle runs, the busy flag is high, and the bus side must refuse access; the block itself ignores loads, addresses, commits, aborts and reads during that window. A single-cycle read port returns array bytes whenever busy is low.

Top module: `pgw_top`

## Requirements
- R1: After reset, busy_o and rd_valid_o are 0 and every array byte reads back as 0x00.
- R2: addr_set_i selects the page (address bits 9:4) and the starting slot (bits 3:0). Each load_i stores its byte at the current slot and advances the slot by one, modulo 16, without changing the page.
- R3: When more than 16 bytes are loaded before a commit, the slot pointer wraps to slot 0 of the same page, and the later byte replaces the earlier one in that slot.
- R4: A commit writes only the slots loaded since the last address set. All other bytes of the array keep their values.
- R5: A commit with wp_i high starts no write cycle (busy_o stays 0), leaves the array unchanged, and discards the latch contents.
- R6: An accepted commit raises busy_o on the next clock. busy_o stays high for exactly WRITE_CYCLES cycles. The new bytes are readable from the first cycle with busy_o low.
- R7: abort_i before the commit clears the valid mask, so a following commit starts no write cycle and changes nothing.
- R8: A new addr_set_i clears the valid mask, so bytes loaded before it are never written.
- R9: A commit with no loaded bytes starts no write cycle.
- R10: While busy_o is high, load_i, addr_set_i, commit_i and abort_i have no effect: the cycle length and the written bytes are unchanged.
- R11: rd_en_i with busy_o low returns the byte at rd_addr_i on rd_data_o with rd_valid_o high on the next cycle. rd_en_i with busy_o high gives rd_valid_o low on the next cycle.

Priority when several controls arrive in one idle cycle: abort_i, then commit_i, then addr_set_i, then load_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load one data byte into the page latch |
| load_data_i | input | 8 | Byte to load |
| addr_set_i | input | 1 | Latch a new starting address and clear the mask |
| addr_i | input | 10 | Starting word address |
| commit_i | input | 1 | STOP seen: commit the latched bytes |
| abort_i | input | 1 | START or abort: discard the latched bytes |
| wp_i | input | 1 | Write protect for this commit |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 10 | Read address |
| rd_data_o | output | 8 | Read data, registered |
| rd_valid_o | output | 1 | Read data valid |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The bench targets the following corner cases:
- Loads that start near the top of a page. A design that carried the pointer into the page bits would write into the next page.
- Runs of 17 or more bytes. A design that dropped the wrap would lose the overwrite.
- Aborts, address restarts, empty commits and write-protected commits. Each must leave the array and busy_o untouched; a stale mask would instead commit old bytes.
- Stimulus during the busy window. A design that still accepted it would stretch the cycle, corrupt the latch, or return reads while the array is being written.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 10;
    localparam int PAGE_BYTES = 16;
    localparam int OFS_W      = $clog2(PAGE_BYTES);
    localparam int PAGE_W     = ADDR_W - OFS_W;
    localparam int DEPTH      = 1 << ADDR_W;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic [PAGE_W-1:0]                page;
        logic [PAGE_BYTES-1:0]            mask;
        logic [PAGE_BYTES-1:0][DATA_W-1:0] data;
    } page_img_t;

    function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic logic [OFS_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
        return a[OFS_W-1:0];
    endfunction
endpackage

// File: rtl/pgw_latch.sv
module pgw_latch
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              load_i,
    input  byte_t             load_data_i,
    input  logic              addr_set_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              commit_i,
    input  logic              abort_i,
    input  logic              wp_i,
    output logic              start_o,
    output page_img_t         img_o
);
    page_img_t        img_q;
    logic [OFS_W-1:0] ptr_q;

    assign start_o = !busy_i && commit_i && !abort_i && !wp_i && (|img_q.mask);
    assign img_o   = img_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            img_q <= '0;
            ptr_q <= '0;
        end else if (busy_i) begin
            if (done_i) img_q.mask <= '0;
        end else if (abort_i) begin
            img_q.mask <= '0;
        end else if (commit_i) begin
            if (!start_o) img_q.mask <= '0;
        end else if (addr_set_i) begin
            img_q.page <= page_of(addr_i);
            img_q.mask <= '0;
            ptr_q      <= slot_of(addr_i);
        end else if (load_i) begin
            img_q.data[ptr_q] <= load_data_i;
            img_q.mask[ptr_q] <= 1'b1;
            ptr_q             <= ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
    parameter int WRITE_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(WRITE_CYCLES - 1);
        end
    end
endmodule

// File: rtl/pgw_array.sv
module pgw_array
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  page_img_t         img_i,
    input  logic              busy_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output byte_t             rd_data_o,
    output logic              rd_valid_o
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (img_i.mask[i]) mem[{img_i.page, OFS_W'(i)}] <= img_i.data[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_en_i && !busy_i;
            if (rd_en_i && !busy_i) rd_data_o <= mem[rd_addr_i];
        end
    end
endmodule

// File: rtl/pgw_top.sv
module pgw_top
    import pgw_pkg::*;
#(
    parameter int WRITE_CYCLES = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load_i,
    input  logic [7:0]  load_data_i,
    input  logic        addr_set_i,
    input  logic [9:0]  addr_i,
    input  logic        commit_i,
    input  logic        abort_i,
    input  logic        wp_i,
    input  logic        rd_en_i,
    input  logic [9:0]  rd_addr_i,
    output logic [7:0]  rd_data_o,
    output logic        rd_valid_o,
    output logic        busy_o
);
    logic      start;
    logic      done;
    logic      busy;
    page_img_t img;

    assign busy_o = busy;

    pgw_latch u_latch (
        .clk(clk), .rst(rst), .busy_i(busy), .done_i(done),
        .load_i(load_i), .load_data_i(load_data_i),
        .addr_set_i(addr_set_i), .addr_i(addr_i),
        .commit_i(commit_i), .abort_i(abort_i), .wp_i(wp_i),
        .start_o(start), .img_o(img)
    );

    pgw_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start_i(start), .busy_o(busy), .done_o(done)
    );

    pgw_array u_array (
        .clk(clk), .rst(rst), .wr_en_i(done), .img_i(img), .busy_i(busy),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
    );
endmodule

// File: rtl/pgw_checks.sv
module pgw_checks #(
    parameter int WRITE_CYCLES = 20
) (
    input logic clk,
    input logic rst,
    input logic commit_i,
    input logic abort_i,
    input logic wp_i,
    input logic rd_en_i,
    input logic rd_valid_o,
    input logic busy_o
);
    int run_q;

    always_ff @(posedge clk) begin
        if (rst)         run_q <= 0;
        else if (busy_o) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    // R6: window length is exactly WRITE_CYCLES
    a_r6_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> run_q == WRITE_CYCLES);

    // R6: busy only follows an unprotected commit
    a_r6_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(commit_i && !wp_i && !abort_i));

    // R5: protected commit never starts a cycle
    a_r5_wp_blocks: assert property (@(posedge clk) disable iff (rst)
        (commit_i && wp_i && !busy_o) |=> !busy_o);

    // R11: reads refused while busy
    a_r11_rd_blocked: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !rd_valid_o);

    // R11: reads served when idle
    a_r11_rd_served: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !busy_o) |=> rd_valid_o);
endmodule

bind pgw_top pgw_checks #(.WRITE_CYCLES(WRITE_CYCLES)) u_checks (
    .clk(clk), .rst(rst), .commit_i(commit_i), .abort_i(abort_i),
    .wp_i(wp_i), .rd_en_i(rd_en_i), .rd_valid_o(rd_valid_o), .busy_o(busy_o)
);

// File: tb/pgw_top_bench.sv
module pgw_top_bench;
    localparam int W = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_i = 0, addr_set_i = 0, commit_i = 0, abort_i = 0, wp_i = 0, rd_en_i = 0;
    logic [7:0] load_data_i = 0;
    logic [9:0] addr_i = 0, rd_addr_i = 0;
    logic [7:0] rd_data_o;
    logic       rd_valid_o, busy_o;

    always #4 clk = ~clk;

    pgw_top #(.WRITE_CYCLES(W)) u_pgw_top (.*);

    logic [7:0] m_mem [1024];
    logic [7:0] m_lat [16];
    logic [15:0] m_mask;
    int m_page, m_ptr;
    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_read(input int a);
        return int'(m_mem[a]);
    endfunction

    task automatic do_set(input int a);
        addr_set_i = 1; addr_i = 10'(a);
        @(negedge clk); addr_set_i = 0;
        m_page = a >> 4; m_ptr = a & 15; m_mask = '0;
    endtask

    task automatic do_load(input int d);
        load_i = 1; load_data_i = 8'(d);
        @(negedge clk); load_i = 0;
        m_lat[m_ptr] = 8'(d); m_mask[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 16;
    endtask

    task automatic do_abort();
        abort_i = 1; @(negedge clk); abort_i = 0;
        m_mask = '0;
    endtask

    task automatic do_commit(input bit wp, input bit disturb, input string req);
        bit exp_start;
        int len;
        exp_start = !wp && (m_mask != 0);
        commit_i = 1; wp_i = wp;
        @(negedge clk); commit_i = 0; wp_i = 0;
        chk(busy_o == exp_start, req, busy_o, exp_start);
        len = 0;
        if (exp_start && disturb) begin
            load_i = 1; load_data_i = 8'hEE; addr_set_i = 1; addr_i = 10'h000;
            abort_i = 1; commit_i = 1; rd_en_i = 1; rd_addr_i = 10'h000;
            @(negedge clk);
            load_i = 0; addr_set_i = 0; abort_i = 0; commit_i = 0; rd_en_i = 0;
            len = 1;
            chk(rd_valid_o == 1'b0, "R11 read during busy", rd_valid_o, 0);
        end
        while (busy_o && len < 1000) begin
            len++;
            @(negedge clk);
        end
        if (exp_start) begin
            chk(len == W, disturb ? "R10 busy length" : "R6 busy length", len, W);
            for (int i = 0; i < 16; i++)
                if (m_mask[i]) m_mem[m_page * 16 + i] = m_lat[i];
        end
        m_mask = '0;
    endtask

    task automatic rd_chk(input int a, input string req);
        rd_en_i = 1; rd_addr_i = 10'(a);
        @(negedge clk); rd_en_i = 0;
        chk(rd_valid_o == 1'b1, {req, " valid"}, rd_valid_o, 1);
        chk(int'(rd_data_o) == model_read(a), req, rd_data_o, model_read(a));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < 1024; i++) m_mem[i] = 8'h00;
        m_mask = '0; m_page = 0; m_ptr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
        chk(rd_valid_o == 1'b0, "R1 rd_valid", rd_valid_o, 0);
        rd_chk(0, "R1 mem low");
        rd_chk(1023, "R1 mem high");

        // R2 sequential slots, R4 neighbours untouched
        do_set(10'h123);
        do_load(8'hAA); do_load(8'hBB); do_load(8'hCC);
        do_commit(0, 0, "R6 start");
        rd_chk(10'h123, "R2 slot3"); rd_chk(10'h125, "R2 slot5");
        rd_chk(10'h122, "R4 untouched below"); rd_chk(10'h126, "R4 untouched above");

        // R2 pointer wrap near page top keeps page bits
        do_set(10'h04E);
        do_load(8'h11); do_load(8'h22); do_load(8'h33);
        do_commit(0, 0, "R6 start");
        rd_chk(10'h040, "R2 wrap stays in page"); rd_chk(10'h050, "R2 next page untouched");

        // R3 overflow overwrites earliest slots
        do_set(10'h200);
        for (int i = 0; i < 18; i++) do_load(i + 1);
        do_commit(0, 0, "R6 start");
        chk(m_mem[10'h200] == 8'd17, "R3 model", m_mem[10'h200], 17);
        rd_chk(10'h200, "R3 slot0 overwritten"); rd_chk(10'h201, "R3 slot1 overwritten");
        rd_chk(10'h202, "R3 slot2 kept");

        // R5 write protect
        do_set(10'h300); do_load(8'h5A);
        do_commit(1, 0, "R5 no busy");
        rd_chk(10'h300, "R5 array unchanged");
        do_commit(0, 0, "R5 latch discarded");

        // R7 abort
        do_set(10'h310); do_load(8'h77); do_abort();
        do_commit(0, 0, "R7 no busy");
        rd_chk(10'h310, "R7 array unchanged");

        // R8 address restart clears mask
        do_set(10'h320); do_load(8'h66); do_set(10'h330);
        do_commit(0, 0, "R8 no busy");
        rd_chk(10'h320, "R8 old byte not written");

        // R9 empty commit
        do_set(10'h340);
        do_commit(0, 0, "R9 no busy");

        // R10 and R11 stimulus during busy
        do_set(10'h3F0); do_load(8'h9C); do_load(8'h9D);
        do_commit(0, 1, "R6 start");
        rd_chk(10'h3F0, "R10 data kept"); rd_chk(10'h000, "R10 no stray write");
        rd_chk(10'h3F2, "R10 no stray load");

        // random transactions
        for (int t = 0; t < 60; t++) begin
            int a, n;
            a = int'($urandom % 1024);
            n = 1 + int'($urandom % 20);
            do_set(a);
            for (int k = 0; k < n; k++) do_load(int'($urandom % 256));
            if ($urandom % 6 == 0) do_abort();
            do_commit(($urandom % 5) == 0, ($urandom % 4) == 0, "R6 random start");
            for (int k = 0; k < 4; k++) rd_chk((a & 10'h3F0) + int'($urandom % 16), "R4 random page");
            rd_chk(int'($urandom % 1024), "R11 random read");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule